// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

Several DMA channels share one bus, and this block picks which channel owns it. Each channel raises a request line. While the bus is free, the arbiter chooses one requester and registers a one-hot grant for it. In the first cycle of that grant it also pulses a grant-valid strobe. The winner keeps the grant until it signals that it is done with the bus.

A channel working in burst mode keeps its release low until its whole transfer is finished. A channel working in cycle-steal mode raises release after every unit, so arbitration runs again between units. The arbiter does not need to know which mode a channel uses: the release line alone decides when ownership ends.

A run-time mode input chooses the ranking. The fixed ranking never changes. The rotating ranking places the channel accepted most recently at the bottom.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant` is all zeros and `grant_valid` is 0.
- R2: With `rr_mode` = 0, the new grant goes to the requesting channel with the lowest index. Bit i of `grant` stands for channel i.
- R3: With `rr_mode` = 1, the new grant goes to the first requesting channel found by counting upward from the last accepted index plus one, wrapping from NUM_CH-1 to 0.
- R4: After reset, the rotating ranking starts with channel 0 highest. The stored last-accepted index resets to NUM_CH-1.
- R5: `grant` never has more than one bit set. Once issued, it stays unchanged while `bus_release` is 0, even when higher-ranked channels request.
- R6: If `bus_release` is 1 while a grant is held, `grant` is zero in the following cycle. That cycle is a free cycle: if any request is present in it, the new grant appears in the cycle after.
- R7: `grant_valid` is 1 only in the first cycle of each new grant, for exactly one cycle.
- R8: A free cycle with no request leaves `grant` at zero and does not change the last-accepted index.
- R9: A change of `rr_mode` while a grant is held does not affect the current owner. The next arbitration uses the new mode.
- R10: `bus_release` has no effect while no grant is held.
- R11: Every accepted grant updates the last-accepted index, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | NUM_CH | Request line of each channel |
| rr_mode | input | 1 | 0 = fixed ranking, 1 = rotating ranking |
| bus_release | input | 1 | The current owner gives the bus back |
| grant | output | NUM_CH | One-hot bus grant, all zeros when the bus is free |
| grant_valid | output | 1 | One-cycle strobe in the first cycle of a new grant |

## Verification
The bench builds the arbiter with NUM_CH = 4, which is the base target. At that size, every one of the 15 nonzero request patterns can be tried against each of the four last-accepted positions, in both modes. This covers every wrap of the rotating search and every fixed-ranking outcome. The remaining directed checks cover burst-style holding, a mode change during a held grant, release pulses on an idle bus, and the free cycle between owners.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Bus ownership state
  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

  // Ranking scheme selected by the mode input
  typedef enum logic {
    RANK_FIXED  = 1'b0,
    RANK_ROTATE = 1'b1
  } rank_mode_e;

endpackage

// File: rtl/dma_arb_fixed_pick.sv
// Lowest-index-wins picker built as a prefix chain.
module dma_arb_fixed_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] pick
);

  // seen[i]: some channel below i requests
  logic [NUM_CH-1:0] seen;

  assign seen[0] = 1'b0;
  assign pick[0] = req[0];

  genvar i;
  generate
    for (i = 1; i < NUM_CH; i++) begin : g_chain
      assign seen[i] = seen[i-1] | req[i-1];
      assign pick[i] = req[i] & ~seen[i];
    end
  endgenerate

endmodule

// File: rtl/dma_arb_rr_pick.sv
// Rotating picker: rotate so the channel after `last` sits at position 0,
// apply the fixed chain, then rotate the result back.
module dma_arb_rr_pick #(
  parameter int NUM_CH = 4,
  parameter int IW     = 2
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IW-1:0]     last,
  output logic [NUM_CH-1:0] pick
);

  logic [NUM_CH-1:0] req_rot;
  logic [NUM_CH-1:0] pick_rot;
  int unsigned       shift;

  always_comb begin
    if (int'(last) >= NUM_CH - 1) shift = 0;
    else                          shift = int'(last) + 1;
  end

  always_comb begin
    for (int j = 0; j < NUM_CH; j++) begin
      req_rot[j] = req[(j + shift) % NUM_CH];
    end
  end

  dma_arb_fixed_pick #(.NUM_CH(NUM_CH)) u_chain (
    .req  (req_rot),
    .pick (pick_rot)
  );

  always_comb begin
    pick = '0;
    for (int j = 0; j < NUM_CH; j++) begin
      pick[(j + shift) % NUM_CH] = pick_rot[j];
    end
  end

endmodule

// File: rtl/dma_arb_encode.sv
// One-hot to index encoder
module dma_arb_encode #(
  parameter int NUM_CH = 4,
  parameter int IW     = 2
) (
  input  logic [NUM_CH-1:0] onehot,
  output logic [IW-1:0]     index
);

  always_comb begin
    index = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (onehot[i]) index = IW'(i);
    end
  end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic              rr_mode,
  input  logic              bus_release,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid
);

  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IW-1:0] LAST_INIT = IW'(NUM_CH - 1);

  arb_state_e        state_q;
  logic [IW-1:0]     last_q;
  logic [NUM_CH-1:0] grant_q;
  logic              valid_q;

  logic [NUM_CH-1:0] fixed_win;
  logic [NUM_CH-1:0] rot_win;
  logic [NUM_CH-1:0] winner;
  logic [IW-1:0]     win_idx;
  rank_mode_e        rank_sel;

  // Both rankings are evaluated every cycle; the mode only steers the mux.
  dma_arb_fixed_pick #(.NUM_CH(NUM_CH)) u_fixed (
    .req  (ch_req),
    .pick (fixed_win)
  );

  dma_arb_rr_pick #(.NUM_CH(NUM_CH), .IW(IW)) u_rot (
    .req  (ch_req),
    .last (last_q),
    .pick (rot_win)
  );

  assign rank_sel = rank_mode_e'(rr_mode);
  assign winner   = (rank_sel == RANK_ROTATE) ? rot_win : fixed_win;

  dma_arb_encode #(.NUM_CH(NUM_CH), .IW(IW)) u_enc (
    .onehot (winner),
    .index  (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_FREE;
      grant_q <= '0;
      valid_q <= 1'b0;
      last_q  <= LAST_INIT;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ARB_FREE: begin
          // Arbitrate only on a free bus; an idle cycle leaves the pointer alone.
          if (|ch_req) begin
            grant_q <= winner;
            valid_q <= 1'b1;
            last_q  <= win_idx;
            state_q <= ARB_HELD;
          end
        end
        ARB_HELD: begin
          // The owner keeps the bus until it releases it (burst or per unit).
          if (bus_release) begin
            grant_q <= '0;
            state_q <= ARB_FREE;
          end
        end
        default: state_q <= ARB_FREE;
      endcase
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_req,
  input logic              rr_mode,
  input logic              bus_release,
  input logic [NUM_CH-1:0] grant,
  input logic              grant_valid
);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !bus_release) |=> (grant == $past(grant)));

  // R6
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && bus_release) |=> (grant == '0));

  // R6
  free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && |ch_req) |=> grant_valid);

  // R7
  valid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (|grant && $past(grant) == '0));

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && ch_req == '0) |=> (grant == '0));

  // R2
  fixed_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && |ch_req && !rr_mode) |=>
      (grant == ($past(ch_req) & (~$past(ch_req) + 1'b1))));

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_req      (ch_req),
  .rr_mode     (rr_mode),
  .bus_release (bus_release),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/dma_prio_arbiter_test.sv
`timescale 1ns/1ps
module dma_prio_arbiter_test;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] ch_req;
  logic           rr_mode;
  logic           bus_release;
  logic [NCH-1:0] grant;
  logic           grant_valid;

  int total = 0;
  int bad   = 0;
  int last  = NCH - 1;   // model of the last accepted channel
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dma_prio_arbiter #(.NUM_CH(NCH)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_req      (ch_req),
    .rr_mode     (rr_mode),
    .bus_release (bus_release),
    .grant       (grant),
    .grant_valid (grant_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] expect_pick(input logic [NCH-1:0] pat,
                                                 input bit mode, input int lst);
    if (!mode) begin
      for (int i = 0; i < NCH; i++) if (pat[i]) return NCH'(1) << i;
    end else begin
      for (int k = 1; k <= NCH; k++) begin
        int idx = (lst + k) % NCH;
        if (pat[idx]) return NCH'(1) << idx;
      end
    end
    return '0;
  endfunction

  function automatic int index_of(input logic [NCH-1:0] oh);
    for (int i = 0; i < NCH; i++) if (oh[i]) return i;
    return 0;
  endfunction

  // Issue one request pattern on a free bus, check the grant, release it.
  task automatic arb_once(input logic [NCH-1:0] pat, input bit mode, input string tag);
    logic [NCH-1:0] exp;
    exp = expect_pick(pat, mode, last);
    ch_req  = pat;
    rr_mode = mode;
    @(negedge clk);
    check(tag, 32'(grant), 32'(exp));
    check({tag, " R7 strobe"}, 32'(grant_valid), 32'd1);
    last = index_of(exp);
    ch_req      = '0;
    bus_release = 1'b1;
    @(negedge clk);
    check("R6 cleared after release", 32'(grant), 32'd0);
    bus_release = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ch_req = '0; rr_mode = 1'b0; bus_release = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 grant in reset", 32'(grant), 32'd0);
    check("R1 valid in reset", 32'(grant_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grant after reset", 32'(grant), 32'd0);

    // R4: rotating ranking starts with channel 0 on top
    arb_once(4'hF, 1'b1, "R4 first rotating pick");

    // Sweep: every pointer position, every pattern, both modes (R2, R3)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < NCH; s++) begin
        for (int p = 1; p < (1 << NCH); p++) begin
          arb_once(NCH'(1) << s, bit'(m), "R11 pointer setup");
          arb_once(NCH'(p), bit'(m), (m == 1) ? "R3 rotating pick" : "R2 fixed pick");
        end
      end
    end

    // R11: a fixed-mode grant moves the pointer used later by rotating mode
    arb_once(4'b0100, 1'b0, "R11 fixed grant");
    arb_once(4'b1111, 1'b1, "R11 rotate after fixed");

    // R5 / R9: burst-style hold against higher-ranked requests, mode flip
    ch_req = 4'b0100; rr_mode = 1'b0;
    @(negedge clk);
    check("R5 burst grant", 32'(grant), 32'h4);
    last = 2;
    ch_req = 4'b1011;
    for (int c = 0; c < 5; c++) begin
      if (c == 2) rr_mode = 1'b1;
      @(negedge clk);
      check("R5 held grant", 32'(grant), 32'h4);
      check("R7 no strobe while held", 32'(grant_valid), 32'd0);
    end
    check("R9 no preempt on mode change", 32'(grant), 32'h4);
    ch_req = 4'b1111;
    bus_release = 1'b1;
    @(negedge clk);
    check("R6 free cycle", 32'(grant), 32'd0);
    check("R6 free cycle strobe", 32'(grant_valid), 32'd0);
    bus_release = 1'b0;
    @(negedge clk);
    check("R9 new mode used", 32'(grant), 32'h8);
    check("R6 grant one cycle after free", 32'(grant_valid), 32'd1);
    last = 3;
    ch_req = '0; bus_release = 1'b1;
    @(negedge clk);
    bus_release = 1'b0;

    // R8 / R10: idle bus with stray release pulses
    for (int c = 0; c < 4; c++) begin
      bus_release = c[0];
      @(negedge clk);
      check("R10 release on idle bus", 32'(grant), 32'd0);
      check("R8 idle valid", 32'(grant_valid), 32'd0);
    end
    bus_release = 1'b0;
    arb_once(4'b1111, 1'b1, "R8 pointer unchanged when idle");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule